// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial engine for a clocked link. Once software raises the start request, a frame of 8 or 16 bits shifts out on the serial data output. In the same frame, bits from the serial data input are gathered, least significant bit first. The shift clock can come from an internal divider of the system clock, and is then driven out on the clock pin. It can also come from a clock pin driven by another device. In that case the pin is brought into the system clock domain through a two-stage synchronizer, and its edges are detected there.

Software loads the data through two byte registers, a low byte and a high byte. 16-bit frames use both; 8-bit frames use only the low byte. When a frame completes, the received bits replace the register contents and a completion flag is raised.

With an external clock, any clock edge that arrives after a frame has ended is an error. The block raises an overrun flag and refuses to start again until that flag is cleared. Between frames the data output keeps its last bit. Software can override that level while the engine is halted.

Top module: `sync_serial_xcvr`

## Requirements
- R1: With `cfgWide`=0 a frame is 8 bits long: it sends `dataLo`, the received byte replaces `dataLo`, and `dataHi` is left unchanged. With `cfgWide`=1 a frame is 16 bits long. The value {`dataHi`,`dataLo`} is sent, and the received 16 bits replace both registers, with the upper byte in `dataHi`.
- R2: Bits go out least significant first. `sdo` changes at each falling shift-clock edge, and `sdi` is sampled at each rising edge. The first bit sampled ends up in bit 0 of the received value.
- R3: A frame starts only on a `startReq` pulse taken while the engine is neither busy nor in overrun. `busy` stays 1 from the start until the last bit has been sampled.
- R4: `irq` goes to 1 at the end of each frame and stays at 1 until an `irqClr` pulse.
- R5: In internal-clock mode (`cfgExtClk`=0), `sckOe` is 1 and `sckOut` idles high. `sckOut` toggles only while busy, with a full period of 2^(`cfgDiv`+1) system clocks. In external-clock mode `sckOe` is 0.
- R6: Between frames `sdo` holds the last bit sent.
- R7: In external-clock mode, shifting follows the falling and rising edges of `sckIn` after synchronization.
- R8: In external-clock mode, a `sckIn` edge after a completed frame sets `overrun`. While `overrun` is 1, no reception takes place, a `startReq` is ignored and the data registers keep their value. An `ovrClr` pulse clears the flag.
- R9: A `levelWe` pulse while halted drives `levelVal` onto `sdo`. While busy it has no effect.
- R10: A `cfgWe` with `cfgMark`=0 aborts the engine: `busy` goes to 0, `sckOut` returns high, and no completion follows. A `cfgWe` with `cfgMark`=1 updates the settings without aborting.
- R11: Writes to `dataLo` and `dataHi` are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Settings write strobe |
| cfgWide | input | 1 | 1 selects 16-bit frames |
| cfgExtClk | input | 1 | 1 selects the external shift clock |
| cfgMark | input | 1 | 0 makes a settings write abort the engine |
| cfgDiv | input | 4 | Internal divider select n, period 2^(n+1) |
| loWe | input | 1 | Low byte write strobe |
| hiWe | input | 1 | High byte write strobe |
| wrData | input | 8 | Byte write data |
| dataLo | output | 8 | Low data byte |
| dataHi | output | 8 | High data byte |
| startReq | input | 1 | Start request pulse |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Frame-complete flag |
| irqClr | input | 1 | Clears irq |
| overrun | output | 1 | Overrun flag |
| ovrClr | input | 1 | Clears overrun |
| levelWe | input | 1 | Idle output level write strobe |
| levelVal | input | 1 | Idle output level value |
| sckIn | input | 1 | External shift clock |
| sckOut | output | 1 | Internal shift clock output |
| sckOe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
Some properties are checked by the assertions on every cycle: the idle-high clock whenever the engine is not busy, the holding of `irq` and `overrun` until cleared, frames starting only from a request, and a steady `sdo` while halted with no level write. Other behaviour can only be shown by the bench's sweeps, because it depends on whole frames. This covers bit order and data contents in both frame lengths, and the measured clock period at each divider setting. It also covers the overrun sequence with an external clock, the ignored writes in mid-frame, and abort versus no abort on a settings write.

// File: rtl/ssx_pkg.sv
`timescale 1ns/1ps
package ssx_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // copy byte registers into the shifter
    logic shiftOut;  // falling shift edge: present next bit
    logic sample;    // rising shift edge: take in sdi
    logic finish;    // last sample of the frame
    logic halted;    // engine idle, host writes allowed
  } ssxStrobe_t;
endpackage

// File: rtl/ssx_ctrl.sv
`timescale 1ns/1ps
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int DIV_BITS    = 4,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic                cfgWide,
  input  logic                cfgExtClk,
  input  logic                cfgMark,
  input  logic [DIV_BITS-1:0] cfgDiv,
  input  logic                startReq,
  input  logic                irqClr,
  input  logic                ovrClr,
  input  logic                sckIn,
  output ssxStrobe_t          strb,
  output logic                wideMode,
  output logic                busy,
  output logic                irq,
  output logic                overrun,
  output logic                sckOut,
  output logic                sckOe
);
  localparam int CNT_W    = (1 << DIV_BITS) - 1;
  localparam int FRAME_MX = 2 * BYTE_W;
  localparam int BIT_W    = $clog2(FRAME_MX);

  logic                   extReg;
  logic [DIV_BITS-1:0]    divReg;
  logic [CNT_W-1:0]       divCnt, halfLim;
  logic [BIT_W-1:0]       bitCnt, frameLast;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sckPrev, sckInt, doneSeen;
  logic                   softRst, startOk, tick, extRise, extFall;
  logic                   fallStb, riseStb, lastBit, ovrSet;

  assign softRst   = cfgWe & ~cfgMark;
  assign startOk   = startReq & ~busy & ~overrun & ~softRst;
  assign halfLim   = ~({CNT_W{1'b1}} << divReg);
  assign tick      = busy & ~extReg & (divCnt == halfLim);
  assign extRise   = syncQ[SYNC_STAGES-1] & ~sckPrev;
  assign extFall   = ~syncQ[SYNC_STAGES-1] & sckPrev;
  assign frameLast = wideMode ? BIT_W'(FRAME_MX - 1) : BIT_W'(BYTE_W - 1);
  assign fallStb   = extReg ? (busy & extFall) : (tick & sckInt);
  assign riseStb   = extReg ? (busy & extRise) : (tick & ~sckInt);
  assign lastBit   = riseStb & (bitCnt == frameLast);
  assign ovrSet    = extReg & doneSeen & ~busy & (extRise | extFall);

  always_comb begin
    strb.load     = startOk;
    strb.shiftOut = fallStb;
    strb.sample   = riseStb;
    strb.finish   = lastBit;
    strb.halted   = ~busy;
  end

  assign sckOut = sckInt;
  assign sckOe  = ~extReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideMode <= 1'b0;
      extReg   <= 1'b0;
      divReg   <= '0;
      busy     <= 1'b0;
      bitCnt   <= '0;
      divCnt   <= '0;
      sckInt   <= 1'b1;
      doneSeen <= 1'b0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
      syncQ    <= '1;
      sckPrev  <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], sckIn};
      sckPrev <= syncQ[SYNC_STAGES-1];
      if (cfgWe) begin
        wideMode <= cfgWide;
        extReg   <= cfgExtClk;
        divReg   <= cfgDiv;
      end
      if (softRst) begin
        busy     <= 1'b0;
        bitCnt   <= '0;
        divCnt   <= '0;
        sckInt   <= 1'b1;
        doneSeen <= 1'b0;
      end else if (startOk) begin
        busy     <= 1'b1;
        bitCnt   <= '0;
        divCnt   <= '0;
        sckInt   <= 1'b1;
        doneSeen <= 1'b0;
      end else begin
        if (tick) begin
          divCnt <= '0;
          sckInt <= ~sckInt;
        end else if (busy && !extReg) begin
          divCnt <= divCnt + 1'b1;
        end
        if (riseStb) begin
          if (lastBit) begin
            busy     <= 1'b0;
            bitCnt   <= '0;
            doneSeen <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
      if (lastBit && !softRst) irq <= 1'b1;
      else if (irqClr)         irq <= 1'b0;
      if (ovrSet)      overrun <= 1'b1;
      else if (ovrClr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/ssx_datapath.sv
`timescale 1ns/1ps
module ssx_datapath
  import ssx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssxStrobe_t        strb,
  input  logic              wideMode,
  input  logic              loWe,
  input  logic              hiWe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              levelWe,
  input  logic              levelVal,
  input  logic              sdi,
  output logic [BYTE_W-1:0] dataLo,
  output logic [BYTE_W-1:0] dataHi,
  output logic              sdo
);
  localparam int SH_W = 2 * BYTE_W;

  logic [SH_W-1:0] shReg, shNext;

  always_comb begin
    if (wideMode) shNext = {sdi, shReg[SH_W-1:1]};
    else          shNext = {shReg[SH_W-1:BYTE_W], sdi, shReg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      dataLo <= '0;
      dataHi <= '0;
      sdo    <= 1'b1;
    end else begin
      if (strb.load)        shReg <= {dataHi, dataLo};
      else if (strb.sample) shReg <= shNext;

      if (strb.finish)                 dataLo <= shNext[BYTE_W-1:0];
      else if (loWe && strb.halted)    dataLo <= wrData;

      if (strb.finish && wideMode)     dataHi <= shNext[SH_W-1:BYTE_W];
      else if (hiWe && strb.halted)    dataHi <= wrData;

      if (strb.shiftOut)               sdo <= shReg[0];
      else if (levelWe && strb.halted) sdo <= levelVal;
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DIV_BITS    = 4,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic                cfgWide,
  input  logic                cfgExtClk,
  input  logic                cfgMark,
  input  logic [DIV_BITS-1:0] cfgDiv,
  input  logic                loWe,
  input  logic                hiWe,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   dataLo,
  output logic [BYTE_W-1:0]   dataHi,
  input  logic                startReq,
  output logic                busy,
  output logic                irq,
  input  logic                irqClr,
  output logic                overrun,
  input  logic                ovrClr,
  input  logic                levelWe,
  input  logic                levelVal,
  input  logic                sckIn,
  output logic                sckOut,
  output logic                sckOe,
  input  logic                sdi,
  output logic                sdo
);
  ssxStrobe_t strb;
  logic       wideMode;

  ssx_ctrl #(.DIV_BITS(DIV_BITS), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWide(cfgWide), .cfgExtClk(cfgExtClk),
    .cfgMark(cfgMark), .cfgDiv(cfgDiv), .startReq(startReq), .irqClr(irqClr),
    .ovrClr(ovrClr), .sckIn(sckIn), .strb(strb), .wideMode(wideMode), .busy(busy),
    .irq(irq), .overrun(overrun), .sckOut(sckOut), .sckOe(sckOe)
  );

  ssx_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wideMode(wideMode), .loWe(loWe), .hiWe(hiWe),
    .wrData(wrData), .levelWe(levelWe), .levelVal(levelVal), .sdi(sdi),
    .dataLo(dataLo), .dataHi(dataHi), .sdo(sdo)
  );
endmodule

// File: rtl/ssx_checker.sv
`timescale 1ns/1ps
module ssx_checker (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic busy,
  input logic irq,
  input logic irqClr,
  input logic overrun,
  input logic ovrClr,
  input logic levelWe,
  input logic sckOut,
  input logic sdo
);
  p_sck_idle_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckOut);

  p_irq_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqClr |=> irq);

  p_irq_on_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(busy));

  p_start_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  p_ovr_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClr |=> overrun);

  p_ovr_blocks_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrun) |-> !$rose(busy));

  p_sdo_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busy) && !$past(levelWe) |-> $stable(sdo));
endmodule

bind sync_serial_xcvr ssx_checker u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .irq(irq),
  .irqClr(irqClr), .overrun(overrun), .ovrClr(ovrClr), .levelWe(levelWe),
  .sckOut(sckOut), .sdo(sdo)
);

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 0, cfgWide = 0, cfgExtClk = 0, cfgMark = 0;
  logic [3:0] cfgDiv = 0;
  logic       loWe = 0, hiWe = 0;
  logic [7:0] wrData = 0;
  logic [7:0] dataLo, dataHi;
  logic       startReq = 0, busy, irq, irqClr = 0, overrun, ovrClr = 0;
  logic       levelWe = 0, levelVal = 0;
  logic       sckIn = 1, sckOut, sckOe, sdi = 0, sdo;
  int         nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  sync_serial_xcvr dut (.*);

  task automatic chkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input bit wide, input bit ext, input bit mark, input int div);
    @(negedge clk);
    cfgWe = 1; cfgWide = wide; cfgExtClk = ext; cfgMark = mark; cfgDiv = 4'(div);
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic wrByte(input bit hi, input logic [7:0] v);
    @(negedge clk);
    wrData = v; loWe = !hi; hiWe = hi;
    @(negedge clk);
    loWe = 0; hiWe = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
  endtask

  task automatic pulseIrqClr();
    @(negedge clk); irqClr = 1;
    @(negedge clk); irqClr = 0;
  endtask

  task automatic writeLevel(input bit v);
    @(negedge clk); levelWe = 1; levelVal = v;
    @(negedge clk); levelWe = 0;
  endtask

  // Internal-clock frame: bench acts as the far end on sckOut
  task automatic runInt(input bit wide, input int div, input logic [15:0] tx, input logic [15:0] rx);
    int n = wide ? 16 : 8;
    int half = 1 << div;
    int badIdle = 0;
    logic [15:0] got = 0;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    time t0 = 0, t1 = 0;
    setCfg(wide, 0, 0, div);
    wrByte(0, tx[7:0]);
    wrByte(1, tx[15:8]);
    idle(6);
    chkEq("R3 no shift clock before start", int'(sckOut), 1);
    chkEq("R3 not busy before start", int'(busy), 0);
    chkEq("R5 sckOe internal", int'(sckOe), 1);
    pulseStart();
    for (int i = 0; i < n; i++) begin
      @(negedge sckOut);
      if (i == 0) t0 = $time;
      if (i == 1) t1 = $time;
      #1 sdi = rx[i];
      @(posedge sckOut);
      got[i] = sdo;
    end
    idle(2);
    chkEq("R4 irq at frame end", int'(irq), 1);
    chkEq("R3 busy cleared at end", int'(busy), 0);
    chkEq("R5 shift clock period", int'((t1 - t0) / 4), 2 * half);
    chkEq("R2 transmitted bits lsb first", int'(got & mask), int'(tx & mask));
    chkEq("R1 R2 received low byte", int'(dataLo), int'(rx[7:0]));
    chkEq("R1 high byte", int'(dataHi), wide ? int'(rx[15:8]) : int'(tx[15:8]));
    chkEq("R6 sdo holds last bit", int'(sdo), int'(tx[n-1]));
    for (int k = 0; k < 8 * half + 4; k++) begin
      @(negedge clk);
      if (sckOut !== 1'b1) badIdle++;
    end
    chkEq("R5 no clock after frame", badIdle, 0);
    chkEq("R4 irq held", int'(irq), 1);
    pulseIrqClr();
    chkEq("R4 irq cleared", int'(irq), 0);
  endtask

  // External-clock frame: bench drives sckIn
  task automatic runExt(input bit wide, input logic [15:0] tx, input logic [15:0] rx, input bit poke);
    int n = wide ? 16 : 8;
    logic [15:0] got = 0;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    sckIn = 1;
    setCfg(wide, 1, 0, 0);
    wrByte(0, tx[7:0]);
    wrByte(1, tx[15:8]);
    chkEq("R5 sckOe external", int'(sckOe), 0);
    pulseStart();
    idle(4);
    for (int i = 0; i < n; i++) begin
      sckIn = 0; sdi = rx[i];
      idle(6);
      got[i] = sdo;
      if (poke && i == 3) begin
        @(negedge clk); levelWe = 1; levelVal = ~sdo; wrData = 8'h5A; hiWe = 1; loWe = 1;
        @(negedge clk); levelWe = 0; hiWe = 0; loWe = 0;
        idle(1);
        chkEq("R9 level write ignored while busy", int'(sdo), int'(got[i]));
      end
      sckIn = 1;
      idle(6);
    end
    chkEq("R7 R4 irq after external frame", int'(irq), 1);
    chkEq("R7 busy cleared", int'(busy), 0);
    chkEq("R7 R2 transmitted bits", int'(got & mask), int'(tx & mask));
    chkEq("R7 R1 received low byte", int'(dataLo), int'(rx[7:0]));
    chkEq("R11 R1 high byte", int'(dataHi), wide ? int'(rx[15:8]) : int'(tx[15:8]));
    chkEq("R8 no overrun yet", int'(overrun), 0);
    sckIn = 0; sdi = ~sdi;
    idle(6);
    chkEq("R8 overrun on extra edge", int'(overrun), 1);
    pulseStart();
    idle(3);
    chkEq("R8 start ignored in overrun", int'(busy), 0);
    sckIn = 1;
    idle(6);
    chkEq("R8 no reception in overrun", int'(dataLo), int'(rx[7:0]));
    @(negedge clk); ovrClr = 1;
    @(negedge clk); ovrClr = 0;
    chkEq("R8 overrun cleared", int'(overrun), 0);
    pulseIrqClr();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    chkEq("R3 reset busy", int'(busy), 0);
    chkEq("R4 reset irq", int'(irq), 0);
    chkEq("R8 reset overrun", int'(overrun), 0);
    chkEq("R5 reset sckOut", int'(sckOut), 1);
    chkEq("R6 reset sdo", int'(sdo), 1);
    chkEq("R1 reset dataLo", int'(dataLo), 0);

    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 4; d++) begin
        logic [15:0] tx = 16'hA5C3 ^ 16'(d * 16'h1357) ^ 16'(w * 16'h0F0F);
        logic [15:0] rx = 16'h3C96 ^ 16'(d * 16'h2468) ^ 16'(w * 16'hF00F);
        runInt(w[0], d, tx, rx);
      end
    for (int b = 0; b < 16; b++)
      runInt(1'b1, 0, 16'(1 << b), ~16'(1 << b));

    writeLevel(0);
    chkEq("R9 idle level low", int'(sdo), 0);
    writeLevel(1);
    chkEq("R9 idle level high", int'(sdo), 1);

    runExt(1'b0, 16'h7E81, 16'h00C5, 1'b1);
    runExt(1'b1, 16'hB46D, 16'h5A0F, 1'b0);

    // R10: settings write with and without abort
    setCfg(0, 0, 0, 5);
    wrByte(0, 8'h99);
    pulseStart();
    idle(40);
    chkEq("R10 busy mid frame", int'(busy), 1);
    setCfg(0, 0, 1, 5);
    chkEq("R10 mark write keeps frame", int'(busy), 1);
    setCfg(0, 0, 0, 5);
    chkEq("R10 abort clears busy", int'(busy), 0);
    chkEq("R10 abort returns clock high", int'(sckOut), 1);
    idle(700);
    chkEq("R10 no completion after abort", int'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule